// File: doc/BRIEF.md
# Multi-Hop Bypass Setup Arbiter

This block is the per-router control for a mesh network in which a flit can cross several routers in one clock cycle. Each router has five ports: four link ports (West, East, North, South) and the Core port. Allocation runs in two stages. In the local stage, flits waiting in this router's input buffers compete for output ports. Each output port has its own round-robin arbiter. The local winners are registered. In the following cycle, the router broadcasts one setup request on each won link output. Each request goes to every downstream router up to `HPC` hops away, and it carries the remaining hop count and the output direction.

In the global stage, the router looks at the setup requests that arrive from upstream routers. Each incoming request sits on a lane that identifies its input port and its distance from the start router. For each input port, the nearest request that still concerns this router becomes that port's candidate. A request concerns this router when its hop count reaches at least this far. The candidate asks for the output named in its direction field, or for Core when this router is its destination. For each output, the nearest contender wins. A flit that won local allocation here counts as distance zero, so it always wins its output.

The winners get their crossbar and bypass controls in the same cycle. A losing candidate is marked stopped, and its flit is written into that input's buffer in the next cycle.

A two-state phase machine controls the local side. In `PH_IDLE`, no local grant is pending. In `PH_SETUP`, a registered local grant is being broadcast and holds its output. The transition `PH_IDLE -> PH_SETUP` happens on any local grant. The transition `PH_SETUP -> PH_IDLE` happens when a cycle produces none. `PH_IDLE -> PH_IDLE` and `PH_SETUP -> PH_SETUP` follow from the same rule.

Top module: `bsa_setup_arb`

## Requirements
- R1: While rst_n is low, lgnt, ssr_out_vld and buf_we are all zero, and the phase machine is in PH_IDLE.
- R2: Ports are coded W=0, E=1, N=2, S=3, Core=4. Input i requests output o when lreq_vld[i] is 1 and lreq_dir[i*3+:3]==o. Each output grants at most one requester. Its search starts at that output's pointer, which resets to input 0, and proceeds upward with wrap-around. The pointer moves to one past the winner, and only in a cycle that has a grant.
- R3: A local grant appears on lgnt one cycle after the request is sampled and lasts one cycle for each sampled request. The phase moves PH_IDLE->PH_SETUP on any grant and PH_SETUP->PH_IDLE on a cycle with none.
- R4: For each granted link output o, in the cycle of R3: ssr_out_vld[o]=1, ssr_out_hop[o*4+:4] equals the winner's lreq_hop, and ssr_out_dir[o*3+:3]=o. All three fields are zero for an unused output.
- R5: The incoming request for input port p at distance d (1..HPC) uses bit p*HPC+d-1 of ssr_in_vld, with 4-bit hop and 3-bit direction fields at the same index. A request whose hop count is below d is ignored.
- R6: Of the requests on one input port that R5 does not ignore, only the nearest one is considered. Farther ones have no effect.
- R7: A considered request whose hop count equals d targets the Core output (eject). Otherwise it targets the output in its direction field.
- R8: For each output, a local winner registered in the previous cycle beats every incoming request. Among incoming requests, the smallest distance wins, and a tie goes to the lowest input index.
- R9: In the same cycle as the requests, a winning incoming request sets xb_vld[o]=1, xb_src[o*3+:3]=p, xb_byp[o]=1 and in_bypass[p]=1. An output with no winner shows xb_vld, xb_src and xb_byp as zero.
- R10: A considered request that loses raises in_stop[p] in the same cycle, and buf_we[p] for exactly the next cycle.
- R11: In PH_SETUP, a local winner drives xb_vld[o]=1, xb_src[o*3+:3] equal to its buffered input index, and xb_byp[o]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_vld | input | 5 | Buffered flit present at each input |
| lreq_dir | input | 15 | Requested output per input, 3 bits each |
| lreq_hop | input | 5*HOP_W | Hops to destination per input |
| ssr_in_vld | input | 4*HPC | Incoming setup request valid, per input port and distance |
| ssr_in_hop | input | 4*HPC*HOP_W | Hop field of each incoming request |
| ssr_in_dir | input | 4*HPC*3 | Direction field of each incoming request |
| lgnt | output | 5 | Local grant per input buffer |
| ssr_out_vld | output | 4 | Setup request broadcast valid per link output |
| ssr_out_hop | output | 4*HOP_W | Broadcast hop field |
| ssr_out_dir | output | 12 | Broadcast direction field |
| xb_vld | output | 5 | Crossbar output in use |
| xb_src | output | 15 | Crossbar source input per output |
| xb_byp | output | 5 | Output fed from the input's bypass path (1) or its buffer (0) |
| in_bypass | output | 4 | Input flit passes through without stopping |
| in_stop | output | 4 | Input flit lost global allocation and stops here |
| buf_we | output | 4 | Input buffer write for a stopped flit |

## Verification
A broken round-robin pointer shows up on lgnt one cycle after the affected request, as a grant to the wrong input. The held-request sweep exposes it within a few patterns. A wrong lane-relevance or priority decision is combinational: it appears on xb_src, in_bypass and in_stop in the same cycle the requests arrive. A fault in the stop latch shows on buf_we exactly one cycle later. A phase-machine fault shows as a missing or stale broadcast on ssr_out_vld, or as a local flit losing its own output.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int NPORT = 5;
    localparam int NLINK = 4;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        PORT_W    = 3'd0,
        PORT_E    = 3'd1,
        PORT_N    = 3'd2,
        PORT_S    = 3'd3,
        PORT_CORE = 3'd4
    } port_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SETUP = 1'b1
    } phase_e;

endpackage

// File: rtl/bsa_rr_arb.sv
module bsa_rr_arb
    import bsa_pkg::*;
#(
    parameter int N = NPORT,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gvld,
    output logic [IW-1:0] gidx
);

    logic [IW-1:0] ptr_q;
    logic [N-1:0]  gnt;

    // search begins at the pointer and wraps
    always_comb begin
        gnt  = '0;
        gvld = 1'b0;
        gidx = '0;
        for (int k = 0; k < N; k++) begin
            if (!gvld && req[(int'(ptr_q) + k) % N]) begin
                gvld = 1'b1;
                gidx = IW'((int'(ptr_q) + k) % N);
                gnt[(int'(ptr_q) + k) % N] = 1'b1;
            end
        end
    end

    // pointer moves only when something was granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gvld) begin
            ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
        end
    end

    // R2
    gnt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((gnt & ~req) == '0) && $onehot0(gnt)));

    // R2
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gvld && $countones(req) > 1) |=> ((req != $past(req)) || (gnt != $past(gnt))));

endmodule

// File: rtl/bsa_lane_pick.sv
module bsa_lane_pick
    import bsa_pkg::*;
#(
    parameter int HPC = 8,
    localparam int HOP_W = $clog2(HPC + 1)
) (
    input  logic [HPC-1:0]       lane_vld,
    input  logic [HPC*HOP_W-1:0] lane_hop,
    input  logic [HPC*PW-1:0]    lane_dir,
    output logic                 cand_vld,
    output logic [HOP_W-1:0]     cand_dist,
    output logic [PW-1:0]        cand_out
);

    logic [HPC-1:0] lane_rel;

    // a lane concerns this router only if its path reaches this far
    generate
        for (genvar d = 0; d < HPC; d++) begin : g_rel
            assign lane_rel[d] = lane_vld[d] &&
                                 (lane_hop[d*HOP_W +: HOP_W] >= HOP_W'(d + 1));
        end
    endgenerate

    // scan far to near so the nearest relevant lane is kept
    always_comb begin
        cand_vld  = 1'b0;
        cand_dist = '0;
        cand_out  = '0;
        for (int d = HPC - 1; d >= 0; d--) begin
            if (lane_rel[d]) begin
                cand_vld  = 1'b1;
                cand_dist = HOP_W'(d + 1);
                cand_out  = (lane_hop[d*HOP_W +: HOP_W] == HOP_W'(d + 1)) ?
                            PW'(PORT_CORE) : lane_dir[d*PW +: PW];
            end
        end
    end

    always_comb begin
        if (cand_vld) begin
            for (int d = 0; d < HPC; d++) begin
                if (d + 1 < int'(cand_dist)) begin
                    // R6
                    nearest_lane_chk: assert (!lane_rel[d]);
                end
            end
        end
    end

endmodule

// File: rtl/bsa_out_grant.sv
module bsa_out_grant
    import bsa_pkg::*;
#(
    parameter int HPC     = 8,
    parameter int PORT_ID = 0,
    localparam int HOP_W  = $clog2(HPC + 1)
) (
    input  logic                   loc_vld,
    input  logic [PW-1:0]          loc_src,
    input  logic [NLINK-1:0]       cand_vld,
    input  logic [NLINK*HOP_W-1:0] cand_dist,
    input  logic [NLINK*PW-1:0]    cand_out,
    output logic                   win_vld,
    output logic [PW-1:0]          win_src,
    output logic                   win_byp,
    output logic [NLINK-1:0]       win_mask
);

    logic [HOP_W-1:0] best_d;
    logic [NLINK-1:0] want;

    generate
        for (genvar p = 0; p < NLINK; p++) begin : g_want
            assign want[p] = cand_vld[p] && (cand_out[p*PW +: PW] == PW'(PORT_ID));
        end
    endgenerate

    // strict compare keeps the lower index on equal distance
    always_comb begin
        win_vld  = 1'b0;
        win_src  = '0;
        win_byp  = 1'b0;
        win_mask = '0;
        best_d   = '0;
        for (int p = 0; p < NLINK; p++) begin
            if (want[p] && (!win_vld || cand_dist[p*HOP_W +: HOP_W] < best_d)) begin
                win_vld     = 1'b1;
                win_byp     = 1'b1;
                win_src     = PW'(p);
                best_d      = cand_dist[p*HOP_W +: HOP_W];
                win_mask    = '0;
                win_mask[p] = 1'b1;
            end
        end
        // distance zero: the locally granted flit owns the output
        if (loc_vld) begin
            win_vld  = 1'b1;
            win_byp  = 1'b0;
            win_src  = loc_src;
            win_mask = '0;
        end
    end

    always_comb begin
        if (win_byp) begin
            for (int p = 0; p < NLINK; p++) begin
                if (want[p]) begin
                    // R8
                    nearest_wins_chk: assert (cand_dist[int'(win_src)*HOP_W +: HOP_W]
                                              <= cand_dist[p*HOP_W +: HOP_W]);
                end
            end
        end
    end

endmodule

// File: rtl/bsa_setup_arb.sv
module bsa_setup_arb
    import bsa_pkg::*;
#(
    parameter int HPC = 8,
    localparam int HOP_W = $clog2(HPC + 1),
    localparam int NLANE = NLINK * HPC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       lreq_vld,
    input  logic [NPORT*PW-1:0]    lreq_dir,
    input  logic [NPORT*HOP_W-1:0] lreq_hop,
    input  logic [NLANE-1:0]       ssr_in_vld,
    input  logic [NLANE*HOP_W-1:0] ssr_in_hop,
    input  logic [NLANE*PW-1:0]    ssr_in_dir,
    output logic [NPORT-1:0]       lgnt,
    output logic [NLINK-1:0]       ssr_out_vld,
    output logic [NLINK*HOP_W-1:0] ssr_out_hop,
    output logic [NLINK*PW-1:0]    ssr_out_dir,
    output logic [NPORT-1:0]       xb_vld,
    output logic [NPORT*PW-1:0]    xb_src,
    output logic [NPORT-1:0]       xb_byp,
    output logic [NLINK-1:0]       in_bypass,
    output logic [NLINK-1:0]       in_stop,
    output logic [NLINK-1:0]       buf_we
);

    // ---------------- local allocation ----------------
    logic [NPORT-1:0][NPORT-1:0] req_mat;
    logic [NPORT-1:0]            sal_vld;
    logic [NPORT-1:0][PW-1:0]    sal_src;
    logic [NPORT-1:0][HOP_W-1:0] sal_hop;

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_sal
            for (genvar i = 0; i < NPORT; i++) begin : g_req
                assign req_mat[o][i] = lreq_vld[i] && (lreq_dir[i*PW +: PW] == PW'(o));
            end
            bsa_rr_arb #(.N(NPORT)) i_rr (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (req_mat[o]),
                .gvld (sal_vld[o]),
                .gidx (sal_src[o])
            );
            assign sal_hop[o] = lreq_hop[int'(sal_src[o])*HOP_W +: HOP_W];
        end
    endgenerate

    // ---------------- phase machine and local winner registers ----------------
    phase_e                      phase_q, phase_d;
    logic [NPORT-1:0]            lw_vld;
    logic [NPORT-1:0][PW-1:0]    lw_src;
    logic [NPORT-1:0][HOP_W-1:0] lw_hop;

    always_comb begin
        unique case (phase_q)
            PH_IDLE:  phase_d = (|sal_vld) ? PH_SETUP : PH_IDLE;
            PH_SETUP: phase_d = (|sal_vld) ? PH_SETUP : PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            lw_vld  <= '0;
            lw_src  <= '0;
            lw_hop  <= '0;
        end else begin
            phase_q <= phase_d;
            lw_vld  <= sal_vld;
            lw_src  <= sal_src;
            lw_hop  <= sal_hop;
        end
    end

    // phase outputs: grants back to buffers and the setup broadcast
    logic [NPORT-1:0] loc_act;

    always_comb begin
        lgnt        = '0;
        ssr_out_vld = '0;
        ssr_out_hop = '0;
        ssr_out_dir = '0;
        loc_act     = '0;
        unique case (phase_q)
            PH_IDLE: begin
                loc_act = '0;
            end
            PH_SETUP: begin
                loc_act = lw_vld;
                for (int o = 0; o < NPORT; o++) begin
                    if (lw_vld[o]) begin
                        lgnt[lw_src[o]] = 1'b1;
                    end
                end
                for (int o = 0; o < NLINK; o++) begin
                    if (lw_vld[o]) begin
                        ssr_out_vld[o]               = 1'b1;
                        ssr_out_hop[o*HOP_W +: HOP_W] = lw_hop[o];
                        ssr_out_dir[o*PW +: PW]       = PW'(o);
                    end
                end
            end
            default: begin
                loc_act = '0;
            end
        endcase
    end

    // ---------------- global allocation ----------------
    logic [NLINK-1:0]            cand_vld;
    logic [NLINK*HOP_W-1:0]      cand_dist;
    logic [NLINK*PW-1:0]         cand_out;
    logic [NPORT-1:0][NLINK-1:0] win_mask;

    generate
        for (genvar p = 0; p < NLINK; p++) begin : g_lane
            bsa_lane_pick #(.HPC(HPC)) i_pick (
                .lane_vld (ssr_in_vld[p*HPC +: HPC]),
                .lane_hop (ssr_in_hop[p*HPC*HOP_W +: HPC*HOP_W]),
                .lane_dir (ssr_in_dir[p*HPC*PW +: HPC*PW]),
                .cand_vld (cand_vld[p]),
                .cand_dist(cand_dist[p*HOP_W +: HOP_W]),
                .cand_out (cand_out[p*PW +: PW])
            );
        end
        for (genvar o = 0; o < NPORT; o++) begin : g_sag
            bsa_out_grant #(.HPC(HPC), .PORT_ID(o)) i_grant (
                .loc_vld  (loc_act[o]),
                .loc_src  (lw_src[o]),
                .cand_vld (cand_vld),
                .cand_dist(cand_dist),
                .cand_out (cand_out),
                .win_vld  (xb_vld[o]),
                .win_src  (xb_src[o*PW +: PW]),
                .win_byp  (xb_byp[o]),
                .win_mask (win_mask[o])
            );
        end
    endgenerate

    always_comb begin
        in_bypass = '0;
        for (int o = 0; o < NPORT; o++) begin
            in_bypass = in_bypass | win_mask[o];
        end
    end

    assign in_stop = cand_vld & ~in_bypass;

    // the stopped flit arrives one cycle later and is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we <= '0;
        end else begin
            buf_we <= in_stop;
        end
    end

    // R10
    stop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop != '0) |=> (buf_we == $past(in_stop)));

    // R9
    byp_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_bypass & in_stop) == '0));

    // R9
    byp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_bypass) == $countones(xb_vld & xb_byp)));

    // R11
    local_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |-> (((lw_vld & xb_byp) == '0) && ((lw_vld & ~xb_vld) == '0)));

    generate
        for (genvar o = 0; o < NLINK; o++) begin : g_hchk
            // R4
            bcast_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ssr_out_vld[o] |-> ((ssr_out_hop[o*HOP_W +: HOP_W] != '0) &&
                                    (int'(ssr_out_hop[o*HOP_W +: HOP_W]) <= HPC)));
        end
    endgenerate

endmodule

// File: tb/test_bsa_setup_arb.sv
module test_bsa_setup_arb;

    localparam int HPC = 8;
    localparam int HW  = 4;
    localparam int NL  = 4 * HPC;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [4:0]        lreq_vld;
    logic [14:0]       lreq_dir;
    logic [5*HW-1:0]   lreq_hop;
    logic [NL-1:0]     ssr_in_vld;
    logic [NL*HW-1:0]  ssr_in_hop;
    logic [NL*3-1:0]   ssr_in_dir;
    logic [4:0]        lgnt;
    logic [3:0]        ssr_out_vld;
    logic [4*HW-1:0]   ssr_out_hop;
    logic [11:0]       ssr_out_dir;
    logic [4:0]        xb_vld;
    logic [14:0]       xb_src;
    logic [4:0]        xb_byp;
    logic [3:0]        in_bypass;
    logic [3:0]        in_stop;
    logic [3:0]        buf_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bsa_setup_arb #(.HPC(HPC)) i_bsa_setup_arb (
        .clk(clk), .rst_n(rst_n),
        .lreq_vld(lreq_vld), .lreq_dir(lreq_dir), .lreq_hop(lreq_hop),
        .ssr_in_vld(ssr_in_vld), .ssr_in_hop(ssr_in_hop), .ssr_in_dir(ssr_in_dir),
        .lgnt(lgnt), .ssr_out_vld(ssr_out_vld), .ssr_out_hop(ssr_out_hop),
        .ssr_out_dir(ssr_out_dir), .xb_vld(xb_vld), .xb_src(xb_src),
        .xb_byp(xb_byp), .in_bypass(in_bypass), .in_stop(in_stop), .buf_we(buf_we)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr_lanes();
        ssr_in_vld = '0;
        ssr_in_hop = '0;
        ssr_in_dir = '0;
    endtask

    task automatic set_lane(input int p, input int d, input int h, input int dr);
        int idx;
        idx = p * HPC + d - 1;
        ssr_in_vld[idx]          = 1'b1;
        ssr_in_hop[idx*HW +: HW] = HW'(h);
        ssr_in_dir[idx*3 +: 3]   = 3'(dr);
    endtask

    function automatic logic [63:0] gview();
        return 64'({xb_vld, xb_src, xb_byp, in_bypass, in_stop});
    endfunction

    function automatic logic [63:0] lview();
        return 64'({lgnt, ssr_out_vld, ssr_out_hop, ssr_out_dir});
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [4:0]      e_vld, e_byp, e_lg;
        logic [14:0]     e_src;
        logic [3:0]      e_ib, e_is, e_sv;
        logic [4*HW-1:0] e_sh;
        logic [11:0]     e_sd;
        int ptr;

        // ---- R1: reset state with requests present ----
        rst_n    = 1'b0;
        lreq_vld = 5'b11111;
        lreq_dir = {5{3'd1}};
        lreq_hop = {5{4'd2}};
        clr_lanes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset lgnt/bcast", lview(), 64'd0);
        chk("R1 reset xbar", 64'({xb_vld, buf_we}), 64'd0);
        lreq_vld = '0;
        rst_n    = 1'b1;
        @(posedge clk);
        @(negedge clk);

        // ---- R2 R3 R4 R11: round-robin sweep, all inputs to East ----
        ptr = 0;
        for (int i = 0; i < 5; i++) lreq_hop[i*HW +: HW] = HW'(i + 1);
        for (int m = 0; m < 32; m++) begin
            int gi;
            gi = -1;
            lreq_vld = 5'(m);
            @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                if (gi < 0 && m[(ptr + k) % 5]) gi = (ptr + k) % 5;
            end
            e_lg = '0; e_sv = '0; e_sh = '0; e_sd = '0;
            e_vld = '0; e_src = '0; e_byp = '0; e_ib = '0; e_is = '0;
            if (gi >= 0) begin
                ptr = (gi + 1) % 5;
                e_lg[gi] = 1'b1;
                e_sv[1]  = 1'b1;
                e_sh[HW +: HW] = HW'(gi + 1);
                e_sd[3 +: 3]   = 3'd1;
                e_vld[1] = 1'b1;
                e_src[3 +: 3] = 3'(gi);
            end
            chk("R2 R3 R4 round-robin grant/broadcast", lview(), 64'({e_lg, e_sv, e_sh, e_sd}));
            chk("R11 local crossbar", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
        end

        // ---- R2 R4 R11: each input to a distinct output ----
        for (int i = 0; i < 5; i++) lreq_dir[i*3 +: 3] = 3'((i + 1) % 5);
        lreq_vld = 5'b11111;
        @(posedge clk);
        @(negedge clk);
        e_lg = 5'b11111; e_sv = 4'b1111; e_sh = '0; e_sd = '0;
        e_vld = 5'b11111; e_src = '0; e_byp = '0; e_ib = '0; e_is = '0;
        for (int o = 0; o < 5; o++) begin
            e_src[o*3 +: 3] = 3'((o + 4) % 5);
            if (o < 4) begin
                e_sh[o*HW +: HW] = HW'((o + 4) % 5 + 1);
                e_sd[o*3 +: 3]   = 3'(o);
            end
        end
        chk("R2 R4 parallel grants", lview(), 64'({e_lg, e_sv, e_sh, e_sd}));
        chk("R11 parallel local crossbar", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
        lreq_vld = '0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 back to idle, no broadcast", lview(), 64'd0);

        // ---- R5 R7 R9: every single lane, every hop count ----
        for (int p = 0; p < 4; p++) begin
            for (int d = 1; d <= HPC; d++) begin
                for (int h = 0; h <= HPC; h++) begin
                    int dr, o;
                    dr = (p + 2) % 4;
                    clr_lanes();
                    set_lane(p, d, h, dr);
                    #1;
                    e_vld = '0; e_src = '0; e_byp = '0; e_ib = '0; e_is = '0;
                    if (h >= d) begin
                        o = (h == d) ? 4 : dr;
                        e_vld[o] = 1'b1;
                        e_src[o*3 +: 3] = 3'(p);
                        e_byp[o] = 1'b1;
                        e_ib[p]  = 1'b1;
                    end
                    if (h < d)       chk("R5 short request ignored", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
                    else if (h == d) chk("R7 eject to Core", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
                    else             chk("R9 bypass controls", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
                end
            end
        end
        clr_lanes();
        @(negedge clk);

        // ---- R8 R10: two inputs contend for North ----
        for (int p = 0; p < 4; p++) begin
            for (int q = p + 1; q < 4; q++) begin
                for (int dp = 1; dp <= 4; dp++) begin
                    for (int dq = 1; dq <= 4; dq++) begin
                        int w, l;
                        clr_lanes();
                        set_lane(p, dp, dp + 2, 2);
                        set_lane(q, dq, dq + 2, 2);
                        #1;
                        w = (dq < dp) ? q : p;
                        l = (w == p) ? q : p;
                        e_vld = 5'b00100; e_src = '0; e_byp = 5'b00100;
                        e_src[6 +: 3] = 3'(w);
                        e_ib = '0; e_ib[w] = 1'b1;
                        e_is = '0; e_is[l] = 1'b1;
                        chk("R8 nearest wins, tie to lower input", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
                        @(posedge clk);
                        @(negedge clk);
                        chk("R10 stopped flit written", 64'(buf_we), 64'(e_is));
                    end
                end
            end
        end
        clr_lanes();
        @(posedge clk);
        @(negedge clk);
        chk("R10 write pulse ends", 64'(buf_we), 64'd0);

        // ---- R6: nearest lane on one input hides farther ones ----
        set_lane(1, 2, 5, 2);
        set_lane(1, 5, 7, 3);
        #1;
        e_vld = 5'b00100; e_src = '0; e_src[6 +: 3] = 3'd1; e_byp = 5'b00100;
        e_ib = 4'b0010; e_is = '0;
        chk("R6 nearest lane per input", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
        clr_lanes();
        set_lane(3, 1, 0, 0);
        set_lane(3, 3, 3, 1);
        #1;
        e_vld = 5'b10000; e_src = '0; e_src[12 +: 3] = 3'd3; e_byp = 5'b10000;
        e_ib = 4'b1000; e_is = '0;
        chk("R5 R7 irrelevant near lane skipped, eject", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));

        // ---- R8 R11 R10: local winner beats incoming request ----
        @(negedge clk);
        clr_lanes();
        lreq_vld = 5'b10000;
        lreq_dir[12 +: 3] = 3'd1;
        lreq_hop[16 +: HW] = 4'd3;
        set_lane(0, 1, 4, 1);
        #1;
        e_vld = 5'b00010; e_src = '0; e_byp = 5'b00010; e_ib = 4'b0001; e_is = '0;
        chk("R9 bypass before local grant", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
        @(posedge clk);
        @(negedge clk);
        e_lg = 5'b10000; e_sv = 4'b0010; e_sh = '0; e_sh[HW +: HW] = 4'd3;
        e_sd = '0; e_sd[3 +: 3] = 3'd1;
        chk("R4 broadcast from Core input", lview(), 64'({e_lg, e_sv, e_sh, e_sd}));
        e_vld = 5'b00010; e_src = '0; e_src[3 +: 3] = 3'd4; e_byp = '0; e_ib = '0; e_is = 4'b0001;
        chk("R8 R11 local flit owns output", gview(), 64'({e_vld, e_src, e_byp, e_ib, e_is}));
        lreq_vld = '0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 loser to local written", 64'(buf_we), 64'd1);
        chk("R3 single grant pulse", 64'(lgnt), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule